// File: doc/BRIEF.md
# Store-to-Load Forwarding Checker

This block decides, for one load per cycle, whether the data it needs can be taken from a store that is still waiting in the store queue. The load arrives with its byte address, its size, and the store-queue position recorded when it was dispatched. The block reads every store entry in parallel. It considers only the stores that are older than the load and not yet written to memory. Among those, the youngest store that touches the load's bytes decides the outcome.

There are four possible outcomes. A store whose byte range contains the whole load gives full forwarding, with the load's bytes extracted from the store data. A store that covers only part of the load gives a partial overlap: the load must be replayed, and the oldest such load is held as the stall record. When no store touches the load, the load goes to memory. An uncacheable load that is not at the head of the load queue is sent back to be rescheduled.

The block also keeps two records. One is the stall record, which is released when the offending store reaches memory. At that point a one-cycle replay pulse names the stalled load. The other is a record of the oldest load that missed while the cache was blocked. The store-queue depth must be a power of two, and one slot serves as the sentinel between the queue's head and its tail.

Top module: `sfwd_checker`

## Requirements
- R1: The entries searched run from `ld_sq_idx`−1 back to `wb_idx` inclusive, with indices wrapping modulo DEPTH. When `ld_sq_idx` equals `wb_idx`, no entry is searched.
- R2: A store entry whose size is 0 is ignored by the search, and so is a store entry whose `st_uncache` bit is set.
- R3: Full forwarding, reported as `res_kind`=1, occurs when ld_addr ≥ st_addr and ld_addr+ld_size ≤ st_addr+st_size both hold. `res_st_idx` then gives the index of the deciding store.
- R4: On full forwarding, `res_data` equals the store data shifted right by 8×(ld_addr AND (st_size−1)) bits, with every byte at or above `ld_size` cleared.
- R5: A partial overlap is any intersection of the two byte ranges without containment. It is reported as `res_kind`=2, with `res_data`=0.
- R6: Only the youngest store in the search window that touches the load decides the result, even when an older store would have forwarded fully.
- R7: A load that no searched store touches is reported as `res_kind`=0, meaning it goes to memory.
- R8: An uncacheable load with `ld_at_head`=0 is reported as `res_kind`=3 and leaves the stall record unchanged. An uncacheable load with `ld_at_head`=1 is searched like any other load.
- R9: A partial overlap sets `stall_active`. It records the store's sequence number, the load's queue index and the load's sequence number. An active record is replaced only by a load with a smaller sequence number.
- R10: When `done_valid` carries the recorded store's sequence number, `stall_active` clears. On the next cycle `replay_valid` is high for exactly one cycle, with `replay_lq_idx` set to the stalled load's index. A sequence number that does not match has no effect.
- R11: A load that goes to memory while `cache_blocked` is high records its sequence number in `blk_seq`, unless a smaller number is already held. Forwarded loads never touch `blk_seq`. `blk_clear` clears `blk_valid`.
- R12: Results are registered. `res_valid` is high in the cycle after each cycle with `ld_valid` high, and low otherwise.
- R13: After reset, `res_valid`, `stall_active`, `replay_valid` and `blk_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_valid | input | 1 | Load request present |
| ld_addr | input | ADDR_W | Load byte address |
| ld_size | input | SIZE_W | Load size in bytes (1..DATA_W/8) |
| ld_sq_idx | input | IDX_W | Store-queue position recorded at dispatch |
| ld_lq_idx | input | LQ_IDX_W | Load-queue index of the load |
| ld_seq | input | SEQ_W | Load sequence number (smaller is older) |
| ld_uncache | input | 1 | Load is uncacheable |
| ld_at_head | input | 1 | Load is at the load-queue head and ready to commit |
| cache_blocked | input | 1 | Cache cannot accept a request this cycle |
| blk_clear | input | 1 | Clears the blocked-load record |
| wb_idx | input | IDX_W | Oldest store not yet written to memory |
| st_addr | input | DEPTH×ADDR_W | Store byte addresses |
| st_size | input | DEPTH×SIZE_W | Store sizes, 0 when data is not yet written |
| st_data | input | DEPTH×DATA_W | Store data |
| st_seq | input | DEPTH×SEQ_W | Store sequence numbers |
| st_uncache | input | DEPTH | Store is uncacheable |
| done_valid | input | 1 | A store finished writing to memory |
| done_seq | input | SEQ_W | Sequence number of the finished store |
| res_valid | output | 1 | Result present |
| res_kind | output | 2 | 0 memory, 1 forward, 2 partial, 3 reschedule |
| res_data | output | DATA_W | Forwarded data |
| res_st_idx | output | IDX_W | Index of the deciding store |
| stall_active | output | 1 | A partial-overlap stall is held |
| stall_st_seq | output | SEQ_W | Sequence number of the stalling store |
| stall_lq_idx | output | LQ_IDX_W | Load-queue index of the stalled load |
| stall_ld_seq | output | SEQ_W | Sequence number of the stalled load |
| replay_valid | output | 1 | One-cycle pulse: the stalled load may replay |
| replay_lq_idx | output | LQ_IDX_W | Load to replay |
| blk_valid | output | 1 | A blocked-load record is held |
| blk_seq | output | SEQ_W | Sequence number of the oldest blocked load |

## Verification
Some properties hold on every cycle and are checked by the assertions. A result follows each load request after exactly one cycle. The age selector never grants more than one store. No store is ever found when the search window is empty. A younger partial overlap never disturbs the stall record. A replay pulse only follows a held stall. The blocked record's sequence number never grows while it is held.

Other behaviours can only be shown by the bench's scenarios, because they need known store contents. These are the window bounds under wrap, the skipping of empty and uncacheable stores, and the byte extraction arithmetic. They also include the youngest-wins choice when an older store would forward fully, and the rescheduling of uncacheable loads.

// File: rtl/sfwd_pkg.sv
package sfwd_pkg;

  typedef enum logic [1:0] {
    RES_MEM     = 2'd0,
    RES_FWD     = 2'd1,
    RES_PART    = 2'd2,
    RES_RESCHED = 2'd3
  } res_kind_e;

  typedef enum logic [1:0] {
    OV_NONE = 2'd0,
    OV_FULL = 2'd1,
    OV_PART = 2'd2
  } overlap_e;

endpackage

// File: rtl/sfwd_classify.sv
module sfwd_classify
  import sfwd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SIZE_W = 4
) (
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [SIZE_W-1:0] ld_size,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [SIZE_W-1:0] st_size,
  input  logic              st_uncache,
  output overlap_e          ov
);

  function automatic overlap_e range_relation(
    input logic [ADDR_W-1:0] la,
    input logic [SIZE_W-1:0] ls,
    input logic [ADDR_W-1:0] sa,
    input logic [SIZE_W-1:0] ss
  );
    logic [ADDR_W:0] l_lo, l_hi, s_lo, s_hi;
    l_lo = {1'b0, la};
    l_hi = l_lo + (ADDR_W+1)'(ls);
    s_lo = {1'b0, sa};
    s_hi = s_lo + (ADDR_W+1)'(ss);
    if (l_lo >= s_lo && l_hi <= s_hi)
      return OV_FULL;
    else if (l_lo < s_hi && l_hi > s_lo)
      return OV_PART;
    else
      return OV_NONE;
  endfunction

  logic live;
  assign live = (st_size != '0) && !st_uncache;

  always_comb begin
    ov = OV_NONE;
    if (live) ov = range_relation(ld_addr, ld_size, st_addr, st_size);
  end

endmodule

// File: rtl/sfwd_age_pick.sv
module sfwd_age_pick #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] start_idx,
  input  logic [IDX_W-1:0] wb_idx,
  input  logic [DEPTH-1:0] hit,
  output logic             found,
  output logic [IDX_W-1:0] sel_idx
);

  logic [IDX_W-1:0] span;
  logic [DEPTH-1:0] cand;
  logic [DEPTH-1:0] grant;

  assign span = start_idx - wb_idx;

  // cand[k]: the k-th entry counting older from the load's position
  always_comb begin
    for (int k = 0; k < DEPTH; k++) begin
      cand[k] = (IDX_W'(k) < span) &&
                hit[start_idx - IDX_W'(1) - IDX_W'(k)];
    end
  end

  assign grant = cand & (~cand + DEPTH'(1));
  assign found = |cand;

  always_comb begin
    sel_idx = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (grant[k]) sel_idx = start_idx - IDX_W'(1) - IDX_W'(k);
    end
  end

  p_grant_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_empty_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_idx == wb_idx) |-> !found);

endmodule

// File: rtl/sfwd_tracker.sv
module sfwd_tracker #(
  parameter int SEQ_W    = 16,
  parameter int LQ_IDX_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                part_ev,
  input  logic [SEQ_W-1:0]    ld_seq,
  input  logic [LQ_IDX_W-1:0] ld_lq_idx,
  input  logic [SEQ_W-1:0]    hit_st_seq,
  input  logic                done_valid,
  input  logic [SEQ_W-1:0]    done_seq,
  input  logic                blk_ev,
  input  logic                blk_clear,
  output logic                stalled,
  output logic [SEQ_W-1:0]    stall_st_seq,
  output logic [LQ_IDX_W-1:0] stall_lq_idx,
  output logic [SEQ_W-1:0]    stall_ld_seq,
  output logic                replay_valid,
  output logic [LQ_IDX_W-1:0] replay_lq_idx,
  output logic                blk_valid,
  output logic [SEQ_W-1:0]    blk_seq
);

  function automatic logic is_older(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
    return a < b;
  endfunction

  logic release_ev, stall_held, stall_take;
  logic blk_held, blk_take;

  assign release_ev = done_valid && stalled && (done_seq == stall_st_seq);
  assign stall_held = stalled && !release_ev;
  assign stall_take = part_ev && (!stall_held || is_older(ld_seq, stall_ld_seq));
  assign blk_held   = blk_valid && !blk_clear;
  assign blk_take   = blk_ev && (!blk_held || is_older(ld_seq, blk_seq));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stalled       <= 1'b0;
      stall_st_seq  <= '0;
      stall_lq_idx  <= '0;
      stall_ld_seq  <= '0;
      replay_valid  <= 1'b0;
      replay_lq_idx <= '0;
    end else begin
      replay_valid <= release_ev;
      if (release_ev) replay_lq_idx <= stall_lq_idx;
      if (stall_take) begin
        stalled      <= 1'b1;
        stall_st_seq <= hit_st_seq;
        stall_lq_idx <= ld_lq_idx;
        stall_ld_seq <= ld_seq;
      end else if (release_ev) begin
        stalled <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_valid <= 1'b0;
      blk_seq   <= '0;
    end else if (blk_take) begin
      blk_valid <= 1'b1;
      blk_seq   <= ld_seq;
    end else if (blk_clear) begin
      blk_valid <= 1'b0;
    end
  end

  p_keep_oldest_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stalled && !release_ev && part_ev && (ld_seq >= stall_ld_seq)) |=> $stable(stall_ld_seq));

  p_replay_follows_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    replay_valid |-> $past(stalled));

  p_blk_never_younger_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && !blk_clear) |=> (blk_valid && blk_seq <= $past(blk_seq)));

endmodule

// File: rtl/sfwd_checker.sv
module sfwd_checker
  import sfwd_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 64,
  parameter int SEQ_W    = 16,
  parameter int LQ_IDX_W = 3,
  localparam int IDX_W      = $clog2(DEPTH),
  localparam int DATA_BYTES = DATA_W / 8,
  localparam int SIZE_W     = $clog2(DATA_BYTES + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ld_valid,
  input  logic [ADDR_W-1:0]             ld_addr,
  input  logic [SIZE_W-1:0]             ld_size,
  input  logic [IDX_W-1:0]              ld_sq_idx,
  input  logic [LQ_IDX_W-1:0]           ld_lq_idx,
  input  logic [SEQ_W-1:0]              ld_seq,
  input  logic                          ld_uncache,
  input  logic                          ld_at_head,
  input  logic                          cache_blocked,
  input  logic                          blk_clear,
  input  logic [IDX_W-1:0]              wb_idx,
  input  logic [DEPTH-1:0][ADDR_W-1:0]  st_addr,
  input  logic [DEPTH-1:0][SIZE_W-1:0]  st_size,
  input  logic [DEPTH-1:0][DATA_W-1:0]  st_data,
  input  logic [DEPTH-1:0][SEQ_W-1:0]   st_seq,
  input  logic [DEPTH-1:0]              st_uncache,
  input  logic                          done_valid,
  input  logic [SEQ_W-1:0]              done_seq,
  output logic                          res_valid,
  output logic [1:0]                    res_kind,
  output logic [DATA_W-1:0]             res_data,
  output logic [IDX_W-1:0]              res_st_idx,
  output logic                          stall_active,
  output logic [SEQ_W-1:0]              stall_st_seq,
  output logic [LQ_IDX_W-1:0]           stall_lq_idx,
  output logic [SEQ_W-1:0]              stall_ld_seq,
  output logic                          replay_valid,
  output logic [LQ_IDX_W-1:0]           replay_lq_idx,
  output logic                          blk_valid,
  output logic [SEQ_W-1:0]              blk_seq
);

  function automatic logic [DATA_W-1:0] pick_bytes(
    input logic [DATA_W-1:0] d,
    input logic [ADDR_W-1:0] la,
    input logic [SIZE_W-1:0] ss,
    input logic [SIZE_W-1:0] ls
  );
    logic [ADDR_W-1:0] off;
    logic [DATA_W-1:0] sh;
    off = la & (ADDR_W'(ss) - ADDR_W'(1));
    sh  = d >> {off, 3'b000};
    for (int b = 0; b < DATA_BYTES; b++) begin
      if (SIZE_W'(b) >= ls) sh[b*8 +: 8] = 8'h00;
    end
    return sh;
  endfunction

  overlap_e [DEPTH-1:0] ov;
  logic     [DEPTH-1:0] hit;

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    sfwd_classify #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_cls (
      .ld_addr   (ld_addr),
      .ld_size   (ld_size),
      .st_addr   (st_addr[i]),
      .st_size   (st_size[i]),
      .st_uncache(st_uncache[i]),
      .ov        (ov[i])
    );
    assign hit[i] = (ov[i] != OV_NONE);
  end

  logic             found;
  logic [IDX_W-1:0] sel_idx;

  sfwd_age_pick #(.DEPTH(DEPTH)) u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_idx(ld_sq_idx),
    .wb_idx   (wb_idx),
    .hit      (hit),
    .found    (found),
    .sel_idx  (sel_idx)
  );

  // Named decision events
  logic      resched_ev, fwd_ev, part_ev, mem_ev, blk_ev;
  res_kind_e kind_d;
  logic [DATA_W-1:0] data_d;

  assign resched_ev = ld_valid && ld_uncache && !ld_at_head;
  assign fwd_ev     = ld_valid && !resched_ev && found && (ov[sel_idx] == OV_FULL);
  assign part_ev    = ld_valid && !resched_ev && found && (ov[sel_idx] == OV_PART);
  assign mem_ev     = ld_valid && !resched_ev && !found;
  assign blk_ev     = mem_ev && cache_blocked;

  always_comb begin
    kind_d = RES_MEM;
    data_d = '0;
    if (resched_ev)   kind_d = RES_RESCHED;
    else if (part_ev) kind_d = RES_PART;
    else if (fwd_ev) begin
      kind_d = RES_FWD;
      data_d = pick_bytes(st_data[sel_idx], ld_addr, st_size[sel_idx], ld_size);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_kind   <= RES_MEM;
      res_data   <= '0;
      res_st_idx <= '0;
    end else begin
      res_valid <= ld_valid;
      if (ld_valid) begin
        res_kind   <= kind_d;
        res_data   <= data_d;
        res_st_idx <= found ? sel_idx : '0;
      end
    end
  end

  sfwd_tracker #(.SEQ_W(SEQ_W), .LQ_IDX_W(LQ_IDX_W)) u_trk (
    .clk          (clk),
    .rst_n        (rst_n),
    .part_ev      (part_ev),
    .ld_seq       (ld_seq),
    .ld_lq_idx    (ld_lq_idx),
    .hit_st_seq   (st_seq[sel_idx]),
    .done_valid   (done_valid),
    .done_seq     (done_seq),
    .blk_ev       (blk_ev),
    .blk_clear    (blk_clear),
    .stalled      (stall_active),
    .stall_st_seq (stall_st_seq),
    .stall_lq_idx (stall_lq_idx),
    .stall_ld_seq (stall_ld_seq),
    .replay_valid (replay_valid),
    .replay_lq_idx(replay_lq_idx),
    .blk_valid    (blk_valid),
    .blk_seq      (blk_seq)
  );

  p_result_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> res_valid);

  p_no_spurious_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |=> !res_valid);

  p_resched_keeps_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (resched_ev && !done_valid) |=> $stable(stall_ld_seq));

endmodule

// File: tb/sfwd_checker_bench.sv
module sfwd_checker_bench;

  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        ld_valid = 0, ld_uncache = 0, ld_at_head = 0, cache_blocked = 0, blk_clear = 0;
  logic [15:0] ld_addr = 0, ld_seq = 0, done_seq = 0;
  logic [3:0]  ld_size = 0;
  logic [2:0]  ld_sq_idx = 0, ld_lq_idx = 0, wb_idx = 0;
  logic [DEPTH-1:0][15:0] st_addr;
  logic [DEPTH-1:0][3:0]  st_size;
  logic [DEPTH-1:0][63:0] st_data;
  logic [DEPTH-1:0][15:0] st_seq;
  logic [DEPTH-1:0]       st_uncache;
  logic        done_valid = 0;

  logic        res_valid, stall_active, replay_valid, blk_valid;
  logic [1:0]  res_kind;
  logic [63:0] res_data;
  logic [2:0]  res_st_idx, stall_lq_idx, replay_lq_idx;
  logic [15:0] stall_st_seq, stall_ld_seq, blk_seq;

  sfwd_checker u_sfwd_checker (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_size(ld_size),
    .ld_sq_idx(ld_sq_idx), .ld_lq_idx(ld_lq_idx), .ld_seq(ld_seq), .ld_uncache(ld_uncache),
    .ld_at_head(ld_at_head), .cache_blocked(cache_blocked), .blk_clear(blk_clear),
    .wb_idx(wb_idx), .st_addr(st_addr), .st_size(st_size), .st_data(st_data),
    .st_seq(st_seq), .st_uncache(st_uncache), .done_valid(done_valid), .done_seq(done_seq),
    .res_valid(res_valid), .res_kind(res_kind), .res_data(res_data), .res_st_idx(res_st_idx),
    .stall_active(stall_active), .stall_st_seq(stall_st_seq), .stall_lq_idx(stall_lq_idx),
    .stall_ld_seq(stall_ld_seq), .replay_valid(replay_valid), .replay_lq_idx(replay_lq_idx),
    .blk_valid(blk_valid), .blk_seq(blk_seq)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one load at a falling edge; return at the next falling edge with the result visible
  task automatic do_load(input logic [15:0] a, input logic [3:0] sz, input logic [2:0] sq,
                         input logic [2:0] lq, input logic [15:0] sq_n,
                         input logic unc, input logic head, input logic blk);
    ld_valid = 1; ld_addr = a; ld_size = sz; ld_sq_idx = sq; ld_lq_idx = lq;
    ld_seq = sq_n; ld_uncache = unc; ld_at_head = head; cache_blocked = blk;
    @(posedge clk); @(negedge clk);
    ld_valid = 0; ld_uncache = 0; ld_at_head = 0; cache_blocked = 0;
  endtask

  task automatic store_done(input logic [15:0] s);
    done_valid = 1; done_seq = s;
    @(posedge clk); @(negedge clk);
    done_valid = 0;
  endtask

  task automatic t_reset;
    chk("R13 res_valid", res_valid, 0);
    chk("R13 stall_active", stall_active, 0);
    chk("R13 replay_valid", replay_valid, 0);
    chk("R13 blk_valid", blk_valid, 0);
  endtask

  task automatic t_full_forward;
    do_load(16'h102, 2, 4, 0, 30, 0, 0, 0);
    chk("R12 res_valid", res_valid, 1);
    chk("R3 kind fwd", res_kind, 1);
    chk("R3 store idx", res_st_idx, 2);
    chk("R4 data offset 2 size 2", res_data, 64'h4433);
    do_load(16'h104, 4, 4, 0, 31, 0, 0, 0);
    chk("R4 data offset 4 size 4", res_data, 64'h8877_6655);
  endtask

  task automatic t_partial_stall;
    do_load(16'h106, 4, 4, 5, 50, 0, 0, 0);
    chk("R5 kind partial", res_kind, 2);
    chk("R5 data zero", res_data, 0);
    chk("R9 stall set", stall_active, 1);
    chk("R9 store seq", stall_st_seq, 22);
    chk("R9 load idx", stall_lq_idx, 5);
    do_load(16'h106, 4, 4, 6, 60, 0, 0, 0);
    chk("R9 younger keeps idx", stall_lq_idx, 5);
    do_load(16'h106, 4, 4, 3, 40, 0, 0, 0);
    chk("R9 older replaces idx", stall_lq_idx, 3);
    chk("R9 older replaces seq", stall_ld_seq, 40);
    store_done(99);
    chk("R10 mismatch keeps stall", stall_active, 1);
    chk("R10 mismatch no replay", replay_valid, 0);
    store_done(22);
    chk("R10 stall cleared", stall_active, 0);
    chk("R10 replay pulse", replay_valid, 1);
    chk("R10 replay idx", replay_lq_idx, 3);
    @(posedge clk); @(negedge clk);
    chk("R10 pulse one cycle", replay_valid, 0);
    chk("R12 idle res_valid low", res_valid, 0);
  endtask

  task automatic t_window;
    wb_idx = 3;
    do_load(16'h100, 4, 4, 0, 30, 0, 0, 0);
    chk("R1 older than wb excluded", res_kind, 0);
    wb_idx = 2;
    do_load(16'h100, 4, 2, 0, 30, 0, 0, 0);
    chk("R1 empty window", res_kind, 0);
    do_load(16'h100, 4, 3, 0, 30, 0, 0, 0);
    chk("R1 wb entry included", res_kind, 1);
    st_addr[7] = 16'h200; st_size[7] = 4; st_data[7] = 64'h0000_0000_DEAD_BEEF;
    wb_idx = 6;
    do_load(16'h202, 2, 1, 0, 30, 0, 0, 0);
    chk("R1 wrap kind", res_kind, 1);
    chk("R1 wrap idx", res_st_idx, 7);
    chk("R4 wrap data", res_data, 64'hDEAD);
    st_size[7] = 0; wb_idx = 0;
    do_load(16'h300, 4, 4, 0, 30, 0, 0, 0);
    chk("R7 no overlap to memory", res_kind, 0);
  endtask

  task automatic t_skip;
    st_addr[3] = 16'h100; st_size[3] = 8; st_data[3] = 64'hAAAA_BBBB_CCCC_DDDD; st_uncache[3] = 1;
    do_load(16'h100, 4, 4, 0, 30, 0, 0, 0);
    chk("R2 uncacheable store skipped", res_st_idx, 2);
    chk("R2 data from older", res_data, 64'h4433_2211);
    st_uncache[3] = 0; st_size[3] = 0;
    do_load(16'h100, 4, 4, 0, 30, 0, 0, 0);
    chk("R2 empty store skipped", res_st_idx, 2);
  endtask

  task automatic t_youngest;
    st_size[3] = 8;
    do_load(16'h100, 4, 4, 0, 30, 0, 0, 0);
    chk("R6 youngest full idx", res_st_idx, 3);
    chk("R6 youngest data", res_data, 64'hCCCC_DDDD);
    st_addr[3] = 16'h104; st_size[3] = 4;
    do_load(16'h100, 8, 4, 1, 45, 0, 0, 0);
    chk("R6 younger partial wins", res_kind, 2);
    chk("R6 partial idx", res_st_idx, 3);
    chk("R9 stall store seq 23", stall_st_seq, 23);
    st_size[3] = 0;
  endtask

  task automatic t_uncache_load;
    do_load(16'h106, 4, 4, 2, 10, 1, 0, 0);
    chk("R8 reschedule kind", res_kind, 3);
    chk("R8 stall untouched", stall_ld_seq, 45);
    do_load(16'h106, 4, 4, 2, 10, 1, 1, 0);
    chk("R8 at head searched", res_kind, 2);
    chk("R8 at head stall seq", stall_ld_seq, 10);
    store_done(22);
    chk("R10 cleanup", stall_active, 0);
  endtask

  task automatic t_blocked;
    do_load(16'h300, 4, 4, 0, 70, 0, 0, 1);
    chk("R11 record", blk_valid, 1);
    chk("R11 seq 70", blk_seq, 70);
    do_load(16'h300, 4, 4, 0, 80, 0, 0, 1);
    chk("R11 younger ignored", blk_seq, 70);
    do_load(16'h300, 4, 4, 0, 65, 0, 0, 1);
    chk("R11 older taken", blk_seq, 65);
    do_load(16'h100, 4, 4, 0, 5, 0, 0, 1);
    chk("R11 forward not recorded", blk_seq, 65);
    blk_clear = 1;
    @(posedge clk); @(negedge clk);
    blk_clear = 0;
    chk("R11 clear", blk_valid, 0);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      st_addr[i] = '0; st_size[i] = '0; st_data[i] = '0; st_seq[i] = 16'(20 + i);
    end
    st_uncache = '0;
    st_addr[2] = 16'h100; st_size[2] = 8; st_data[2] = 64'h8877_6655_4433_2211;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_full_forward();
    t_partial_stall();
    t_window();
    t_skip();
    t_youngest();
    t_uncache_load();
    t_blocked();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule